// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block is the hazard logic for a five-stage in-order pipeline. It looks at the two source register numbers of the instruction now in decode. It compares them with the destination numbers of the three older instructions, which sit in execute, memory and writeback. For each operand it produces a select code. The datapath uses that code to take the operand from the register file or from one of the three later stages.

One case cannot be covered by forwarding. When the instruction in execute is a load and the decode instruction needs its result, the data does not exist yet. The unit then raises a stall. A stalled cycle does three things: the program counter keeps its value, the decode instruction register keeps its value, and the decode-to-execute register loads a bubble with all control cleared. One cycle later the load has reached memory. The dependent instruction then picks up the loaded value through the memory-stage path.

The unit is purely combinational and has no clock. All of its outputs refer to the current contents of the pipeline.

Top module: `fwd_stall_unit`

## Requirements
- R1: Each operand select uses this encoding: 0 takes the register file value, 1 the execute-stage result, 2 the memory-stage result and 3 the writeback-stage result.
- R2: A source register number of zero always gives select 0, whatever the older stages hold.
- R3: A stage counts as a producer only if its register-write enable is 1 and its destination number equals the source number. If the numbers match but the enable is 0, that stage is ignored.
- R4: When more than one stage matches, the newest one wins: execute (1) beats memory (2), and memory beats writeback (3).
- R5: The operand A select depends only on rs_dec and the operand B select only on rt_dec. The two are resolved independently within the same evaluation.
- R6: stall is 1 exactly when ex_mem_rd is 1 and at least one of the two selects equals 1.
- R7: No stall is raised in three cases: a load sits in memory or writeback, the load in execute has no matching nonzero source, or the execute stage matches but is not a load. The selects keep their normal values in all three cases.
- R8: pc_hold, dec_hold and ex_bubble are each 1 exactly in the cycles where stall is 1.
- R9: A non-load result in execute is forwarded with select 1 and without any stall.
- R10: After a one-cycle load-use stall, the bubble in execute has a write enable of 0 and the load sits in memory. The held dependent instruction then receives select 2 and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_dec | input | REG_W | First source register number of the decode instruction |
| rt_dec | input | REG_W | Second source register number of the decode instruction |
| ex_rd | input | REG_W | Destination number of the instruction in execute |
| ex_reg_we | input | 1 | Register-write enable of the execute instruction |
| ex_mem_rd | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination number of the instruction in memory |
| mem_reg_we | input | 1 | Register-write enable of the memory instruction |
| wb_rd | input | REG_W | Destination number of the instruction in writeback |
| wb_reg_we | input | 1 | Register-write enable of the writeback instruction |
| fwd_a_sel | output | 2 | Operand A source select (encoding in R1) |
| fwd_b_sel | output | 2 | Operand B source select (encoding in R1) |
| stall | output | 1 | Load-use hazard detected |
| pc_hold | output | 1 | Keep the program counter unchanged |
| dec_hold | output | 1 | Keep the decode instruction register unchanged |
| ex_bubble | output | 1 | Clear the control fields loaded into execute |

## Verification
The hardest situation to reach is the cycle right after a stall. In that cycle the bubble has replaced the dependent instruction's producer in execute, and the load has moved into memory. Driving the ports by hand would hide any mismatch in this handoff. So the bench contains a small pipeline shell that shifts its own stage registers, using the unit's hold and bubble outputs to decide how to shift. It then checks that the held instruction switches to the memory path and that the stall drops. The priority cases are set up by loading the same register number into two or three stages at once, with selected write enables cleared.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int HZ_STAGES = 3;
  localparam int HZ_SEL_W  = $clog2(HZ_STAGES + 1);

  typedef enum logic [HZ_SEL_W-1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } opnd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wr_en,
  output logic             hit
);
  always_comb begin
    hit = wr_en && (src != '0) && (src == dst);
  end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import hazard_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int STAGES = HZ_STAGES,
  localparam int SEL_W = $clog2(STAGES + 1)
) (
  input  logic [REG_W-1:0]        src,
  input  logic [STAGES*REG_W-1:0] dst_vec,
  input  logic [STAGES-1:0]       we_vec,
  output logic [SEL_W-1:0]        sel
);
  logic [STAGES-1:0] hit;

  // One comparator per producer stage; index 0 is the newest.
  for (genvar g = 0; g < STAGES; g++) begin : g_cmp
    fwd_match #(.REG_W(REG_W)) cmp_i (
      .src  (src),
      .dst  (dst_vec[g*REG_W +: REG_W]),
      .wr_en(we_vec[g]),
      .hit  (hit[g])
    );
  end

  // Scan from oldest to newest so the newest hit is written last.
  always_comb begin
    sel = '0;
    for (int i = STAGES - 1; i >= 0; i--) begin
      if (hit[i]) sel = SEL_W'(i + 1);
    end
  end

  always_comb begin
    if (!$isunknown({src, dst_vec, we_vec, sel})) begin
      assert_zero_src_R2: assert (src != '0 || sel == '0)
        else $error("register zero was forwarded");
      if (sel != '0) begin
        assert_producer_valid_R3: assert (we_vec[int'(sel) - 1] &&
            dst_vec[(int'(sel) - 1)*REG_W +: REG_W] == src)
          else $error("select points at a non-producing stage");
        for (int j = 0; j < STAGES; j++) begin
          if (j < int'(sel) - 1) begin
            assert_newest_wins_R4: assert (!(we_vec[j] &&
                dst_vec[j*REG_W +: REG_W] == src))
              else $error("older stage chosen over a newer match");
          end
        end
      end else begin
        for (int j = 0; j < STAGES; j++) begin
          assert_no_missed_match_R3: assert (src == '0 || !(we_vec[j] &&
              dst_vec[j*REG_W +: REG_W] == src))
            else $error("matching producer was not selected");
        end
      end
    end
  end
endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
  import hazard_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int SEL_W   = HZ_SEL_W
) (
  input  logic                     ex_is_load,
  input  logic [NUM_SRC*SEL_W-1:0] sel_vec,
  output logic                     stall,
  output logic                     pc_hold,
  output logic                     dec_hold,
  output logic                     ex_bubble
);
  logic [NUM_SRC-1:0] wants_ex;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_want
    assign wants_ex[k] = (sel_vec[k*SEL_W +: SEL_W] == SEL_W'(SRC_EX));
  end

  always_comb begin
    stall     = ex_is_load && (|wants_ex);
    pc_hold   = stall;
    dec_hold  = stall;
    ex_bubble = stall;
  end

  always_comb begin
    if (!$isunknown({ex_is_load, sel_vec, stall})) begin
      assert_stall_needs_load_R6: assert (!stall || ex_is_load)
        else $error("stall without a load in execute");
      assert_load_use_stalls_R6: assert (stall || !ex_is_load || wants_ex == '0)
        else $error("load-use dependency not stalled");
    end
  end
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0]    rs_dec,
  input  logic [REG_W-1:0]    rt_dec,
  input  logic [REG_W-1:0]    ex_rd,
  input  logic                ex_reg_we,
  input  logic                ex_mem_rd,
  input  logic [REG_W-1:0]    mem_rd,
  input  logic                mem_reg_we,
  input  logic [REG_W-1:0]    wb_rd,
  input  logic                wb_reg_we,
  output logic [HZ_SEL_W-1:0] fwd_a_sel,
  output logic [HZ_SEL_W-1:0] fwd_b_sel,
  output logic                stall,
  output logic                pc_hold,
  output logic                dec_hold,
  output logic                ex_bubble
);
  localparam int NUM_SRC = 2;

  // Producer stages, newest first: execute, memory, writeback.
  logic [HZ_STAGES*REG_W-1:0]    dst_vec;
  logic [HZ_STAGES-1:0]          we_vec;
  logic [NUM_SRC*REG_W-1:0]      src_vec;
  logic [NUM_SRC*HZ_SEL_W-1:0]   sel_vec;

  assign dst_vec = {wb_rd, mem_rd, ex_rd};
  assign we_vec  = {wb_reg_we, mem_reg_we, ex_reg_we};
  assign src_vec = {rt_dec, rs_dec};

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
    fwd_select #(.REG_W(REG_W), .STAGES(HZ_STAGES)) sel_i (
      .src    (src_vec[k*REG_W +: REG_W]),
      .dst_vec(dst_vec),
      .we_vec (we_vec),
      .sel    (sel_vec[k*HZ_SEL_W +: HZ_SEL_W])
    );
  end

  assign fwd_a_sel = sel_vec[0 +: HZ_SEL_W];
  assign fwd_b_sel = sel_vec[HZ_SEL_W +: HZ_SEL_W];

  load_use_stall #(.NUM_SRC(NUM_SRC), .SEL_W(HZ_SEL_W)) stall_i (
    .ex_is_load(ex_mem_rd),
    .sel_vec   (sel_vec),
    .stall     (stall),
    .pc_hold   (pc_hold),
    .dec_hold  (dec_hold),
    .ex_bubble (ex_bubble)
  );

  always_comb begin
    if (!$isunknown({rs_dec, rt_dec, ex_rd, ex_reg_we, ex_mem_rd, fwd_a_sel,
                     fwd_b_sel, stall, pc_hold, dec_hold, ex_bubble})) begin
      assert_hold_tracks_stall_R8: assert (pc_hold == stall && dec_hold == stall
                                           && ex_bubble == stall)
        else $error("freeze controls disagree with stall");
      assert_exec_fwd_R9: assert (!(ex_reg_we && rs_dec != '0 && rs_dec == ex_rd)
                                  || fwd_a_sel == SRC_EX)
        else $error("execute producer not forwarded on A");
      assert_nonload_nostall_R7: assert (ex_mem_rd || !stall)
        else $error("stall raised without a load in execute");
    end
  end
endmodule

// File: tb/fwd_stall_unit_tb_top.sv
module fwd_stall_unit_tb_top;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [RW-1:0] rs_dec = '0, rt_dec = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic ex_reg_we = 1'b0, ex_mem_rd = 1'b0, mem_reg_we = 1'b0, wb_reg_we = 1'b0;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic stall, pc_hold, dec_hold, ex_bubble;

  fwd_stall_unit #(.REG_W(RW)) dut_i (
    .rs_dec(rs_dec), .rt_dec(rt_dec), .ex_rd(ex_rd), .ex_reg_we(ex_reg_we),
    .ex_mem_rd(ex_mem_rd), .mem_rd(mem_rd), .mem_reg_we(mem_reg_we),
    .wb_rd(wb_rd), .wb_reg_we(wb_reg_we), .fwd_a_sel(fwd_a_sel),
    .fwd_b_sel(fwd_b_sel), .stall(stall), .pc_hold(pc_hold),
    .dec_hold(dec_hold), .ex_bubble(ex_bubble)
  );

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       st;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Model written from R1-style encoding and R2/R3/R4 rules.
  function automatic logic [1:0] want_sel(logic [RW-1:0] s,
      logic [RW-1:0] e, logic ew, logic [RW-1:0] m, logic mw,
      logic [RW-1:0] w, logic ww);
    if (s == 0) return 2'd0;
    if (ew && e == s) return 2'd1;
    if (mw && m == s) return 2'd2;
    if (ww && w == s) return 2'd3;
    return 2'd0;
  endfunction

  // Driver: apply inputs just after the edge and queue the expectation.
  task automatic drive(input logic [RW-1:0] s, t, e, input logic ew, el,
                       input logic [RW-1:0] m, input logic mw,
                       input logic [RW-1:0] w, input logic ww, input string req);
    exp_t x;
    @(posedge clk); #1;
    rs_dec = s; rt_dec = t; ex_rd = e; ex_reg_we = ew; ex_mem_rd = el;
    mem_rd = m; mem_reg_we = mw; wb_rd = w; wb_reg_we = ww;
    x.a = want_sel(s, e, ew, m, mw, w, ww);
    x.b = want_sel(t, e, ew, m, mw, w, ww);
    x.st = el && (x.a == 2'd1 || x.b == 2'd1);
    x.req = req;
    exp_q.push_back(x);
  endtask

  // Monitor: compare on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        exp_t x;
        x = exp_q.pop_front();
        n_tests++;
        if (fwd_a_sel !== x.a || fwd_b_sel !== x.b || stall !== x.st ||
            pc_hold !== x.st || dec_hold !== x.st || ex_bubble !== x.st) begin
          n_fail++;
          $display("FAIL %s: a=%0d b=%0d st=%0b h=%0b%0b%0b expected a=%0d b=%0d st=%0b",
                   x.req, fwd_a_sel, fwd_b_sel, stall, pc_hold, dec_hold,
                   ex_bubble, x.a, x.b, x.st);
        end
      end
    end
  end

  task automatic check_direct(input logic [1:0] a, input logic st, input string req);
    n_tests++;
    if (fwd_a_sel !== a || stall !== st) begin
      n_fail++;
      $display("FAIL %s: a=%0d st=%0b expected a=%0d st=%0b",
               req, fwd_a_sel, stall, a, st);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  // Pipeline shell state for R10.
  logic [RW-1:0] sh_ex_rd, sh_mem_rd, sh_wb_rd;
  logic sh_ex_we, sh_ex_ld, sh_mem_we, sh_wb_we;

  initial begin
    // Idle / reset-like state: every select 0, no stall (R1, R8).
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    drive(3, 0, 0, 0, 0, 0, 0, 3, 1, "R1 wb path");
    drive(3, 0, 0, 0, 0, 3, 1, 0, 0, "R1 mem path");
    drive(0, 7, 7, 1, 0, 0, 0, 0, 0, "R9 ex forward no stall");
    drive(0, 0, 0, 1, 1, 0, 1, 0, 1, "R2 zero source");
    drive(4, 0, 4, 0, 0, 0, 0, 0, 0, "R3 ex enable clear");
    drive(4, 0, 4, 0, 0, 4, 1, 4, 0, "R3 falls to mem");
    drive(6, 0, 6, 1, 0, 6, 1, 6, 1, "R4 all match");
    drive(6, 0, 1, 1, 0, 6, 1, 6, 1, "R4 mem over wb");
    drive(2, 9, 2, 1, 0, 0, 0, 9, 1, "R5 independent");
    drive(9, 2, 2, 1, 0, 0, 0, 9, 1, "R5 swapped");
    drive(0, 8, 8, 1, 1, 0, 0, 0, 0, "R6 load use on B");
    drive(8, 8, 8, 1, 1, 0, 0, 0, 0, "R6 R8 load use both");
    drive(1, 3, 8, 1, 1, 1, 1, 3, 1, "R7 load no match");
    drive(8, 0, 5, 1, 0, 8, 1, 0, 0, "R7 load in mem");
    drive(5, 0, 5, 1, 0, 0, 0, 0, 0, "R7 nonload ex match");
    for (int r = 1; r < 32; r++)
      drive(RW'(r), RW'(31 - r), 0, 0, 0, RW'(31 - r), 1, RW'(r), 1, "R1 sweep");
    @(posedge clk); #1;
    while (exp_q.size() != 0) @(posedge clk);

    // R10: shell with load r5 in execute, decode needs r5.
    sh_ex_rd = 5; sh_ex_we = 1; sh_ex_ld = 1;
    sh_mem_rd = 0; sh_mem_we = 0; sh_wb_rd = 0; sh_wb_we = 0;
    @(posedge clk); #1;
    rs_dec = 5; rt_dec = 0;
    ex_rd = sh_ex_rd; ex_reg_we = sh_ex_we; ex_mem_rd = sh_ex_ld;
    mem_rd = sh_mem_rd; mem_reg_we = sh_mem_we; wb_rd = sh_wb_rd; wb_reg_we = sh_wb_we;
    #1 check_direct(2'd1, 1'b1, "R10 stall cycle");
    @(posedge clk); #1;
    sh_wb_rd = sh_mem_rd; sh_wb_we = sh_mem_we;
    sh_mem_rd = sh_ex_rd; sh_mem_we = sh_ex_we;
    if (ex_bubble) begin
      sh_ex_rd = 0; sh_ex_we = 0; sh_ex_ld = 0;
    end
    // decode held when dec_hold was set; rs stays 5
    ex_rd = sh_ex_rd; ex_reg_we = sh_ex_we; ex_mem_rd = sh_ex_ld;
    mem_rd = sh_mem_rd; mem_reg_we = sh_mem_we; wb_rd = sh_wb_rd; wb_reg_we = sh_wb_we;
    #1 check_direct(2'd2, 1'b0, "R10 after stall");
    @(posedge clk); #1;
    finish_run();
  end
endmodule